// File: doc/BRIEF.md
# Interleaved Block Refill Controller

This block serves whole-block transfers between a cache and a main memory built from four word-interleaved banks. A block has four words, and the four words of a block sit in four different banks at the same row. The controller takes one block request and sends one row address to all four banks in a single cycle. The four slow bank accesses then run side by side. After that, the four words come back one per cycle over a one-word response bus, with a flag on the final word.

A refill therefore costs one address cycle, plus one shared access time of 15 cycles, plus four transfer cycles: 20 cycles in total. Four accesses done one after another would cost far more. A block write uses the same path. It delivers one word to each bank and completes after the same shared access time. The controller handles one request at a time, and a new request is taken only after the previous one has finished.

The bank models are synchronous arrays with a fixed access delay. They are part of the block.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `rsp_valid`, `rsp_last` and `wr_done` are 0.
- R2: Word k (k = 0..3) of block b lives in bank k at row b, so its word address is 4*b + k. Blocks with different indices, including block 0 and the highest block, hold independent data.
- R3: Take the clock edge that accepts a read (`req_valid` and `req_ready` both 1) as edge 0, and call the cycle ending at edge n cycle n. Then `rsp_valid` is 1 exactly in cycles 17 to 20, and `rsp_last` is 1 only in cycle 20. The final word is therefore taken at edge 20.
- R4: The response word in cycle 17 + k comes from bank k, in ascending order starting at word 0 of the block.
- R5: `req_ready` is 0 from cycle 1 until the request completes. It is 1 again from cycle 21 after a read and from cycle 18 after a write. A `req_valid` raised while `req_ready` is 0 is ignored and changes neither timing nor data.
- R6: On a write, `req_wdata` bits [32k+31:32k] are stored as word k of the block. `wr_done` is 1 only in cycle 17, and `rsp_valid` stays 0 for the whole write.
- R7: A read returns, for each word, the value of the most recent write to that block. This includes a block that has been overwritten.
- R8: All four banks start their access on the same edge. No response data and no write completion appears before the 15-cycle bank access has ended, so `rsp_valid` and `wr_done` are 0 through cycle 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| req_valid | input | 1 | Block request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = block write, 0 = block read |
| req_blk | input | ADDR_W-2 (8) | Block index, which is the row used in every bank |
| req_wdata | input | 4*DATA_W (128) | Write data, word k in bits [32k+31:32k] |
| rsp_valid | output | 1 | Response word present |
| rsp_last | output | 1 | Final word of the block |
| rsp_data | output | DATA_W (32) | Response word |
| wr_done | output | 1 | One-cycle pulse when a block write has completed |

## Verification
Every result is timed from the accepting edge.

- **Reads:** one address cycle and fifteen access cycles put the four response words in cycles 17 to 20, and `req_ready` returns in cycle 21.
- **Writes:** the completion pulse falls in cycle 17, and `req_ready` returns in cycle 18.

The bench counts cycles after the accepting edge and samples on the falling edge inside each counted cycle. In every cycle it compares valid, last, done, ready and data against the cycle number. An early, late or missing word is therefore caught in the exact cycle where it goes wrong. Random requests raised during busy periods test that a request is not taken while busy.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int BANKS      = 4;
  localparam int BANK_SEL_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_XFER,
    ST_WDONE
  } seq_state_t;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W     = 32,
  parameter int ROW_W      = 8,
  parameter int ACCESS_CYC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  localparam int DEPTH = 2 ** ROW_W;
  localparam int CNT_W = $clog2(ACCESS_CYC + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  // storage array: written when a write access starts
  always_ff @(posedge clk) begin
    if (start && we) mem[row] <= wdata;
  end

  // read word is captured when the access starts; it is released by the delay counter
  always_ff @(posedge clk) begin
    if (start && !we) rd_q <= mem[row];
  end

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CNT_W'(ACCESS_CYC);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rdata = rd_q;
  assign ready = (cnt_q == '0);
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int ROW_W      = 8,
  parameter int ACCESS_CYC = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ROW_W-1:0]      req_row,
  output logic                  req_ready,
  output logic                  accept,
  output logic                  bank_start,
  output logic                  bank_we,
  output logic [ROW_W-1:0]      bank_row,
  output logic [BANK_SEL_W-1:0] beat,
  output logic                  rsp_valid,
  output logic                  rsp_last,
  output logic                  wr_done
);
  localparam int CNT_W = $clog2(ACCESS_CYC + 1);
  localparam logic [BANK_SEL_W-1:0] LAST_BEAT = BANK_SEL_W'(BANKS - 1);

  seq_state_t            state_q, state_d;
  logic [ROW_W-1:0]      row_q;
  logic                  we_q;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [BANK_SEL_W-1:0] beat_q, beat_d;
  logic                  cnt_en, beat_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    cnt_en  = 1'b0;
    beat_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        cnt_en  = 1'b1;
        cnt_d   = CNT_W'(ACCESS_CYC - 1);
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == '0) begin
          beat_en = 1'b1;
          beat_d  = '0;
          state_d = we_q ? ST_WDONE : ST_XFER;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end
      ST_XFER: begin
        if (beat_q == LAST_BEAT) begin
          state_d = ST_IDLE;
        end else begin
          beat_en = 1'b1;
          beat_d  = beat_q + 1'b1;
        end
      end
      ST_WDONE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      we_q  <= 1'b0;
    end else if (accept) begin
      row_q <= req_row;
      we_q  <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign bank_start = (state_q == ST_ADDR);
  assign bank_we    = we_q;
  assign bank_row   = row_q;
  assign beat       = beat_q;
  assign rsp_valid  = (state_q == ST_XFER);
  assign rsp_last   = (state_q == ST_XFER) && (beat_q == LAST_BEAT);
  assign wr_done    = (state_q == ST_WDONE);
endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl
  import ilv_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 10,
  parameter int ACCESS_CYC = 15,
  localparam int BLK_W     = ADDR_W - BANK_SEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [BLK_W-1:0]        req_blk,
  input  logic [BANKS*DATA_W-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic                    rsp_last,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    wr_done
);
  logic                    accept;
  logic                    bank_start;
  logic                    bank_we;
  logic [BLK_W-1:0]        bank_row;
  logic [BANK_SEL_W-1:0]   beat;
  logic [BANKS*DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0]       bank_rd [BANKS];
  logic [BANKS-1:0]        bank_rdy;

  ilv_seq #(
    .ROW_W      (BLK_W),
    .ACCESS_CYC (ACCESS_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_row    (req_blk),
    .req_ready  (req_ready),
    .accept     (accept),
    .bank_start (bank_start),
    .bank_we    (bank_we),
    .bank_row   (bank_row),
    .beat       (beat),
    .rsp_valid  (rsp_valid),
    .rsp_last   (rsp_last),
    .wr_done    (wr_done)
  );

  // block write data is held from acceptance until the banks sample it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (accept) wdata_q <= req_wdata;
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    ilv_bank #(
      .DATA_W     (DATA_W),
      .ROW_W      (BLK_W),
      .ACCESS_CYC (ACCESS_CYC)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .start (bank_start),
      .we    (bank_we),
      .row   (bank_row),
      .wdata (wdata_q[g*DATA_W +: DATA_W]),
      .rdata (bank_rd[g]),
      .ready (bank_rdy[g])
    );
  end

  assign rsp_data = bank_rd[beat];
endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk
  import ilv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_last,
  input logic             wr_done,
  input logic [BANKS-1:0] bank_rdy
);
  a_r3_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  a_r3_burst_four: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> !rsp_last ##1 (rsp_valid && !rsp_last) ##1 (rsp_valid && !rsp_last) ##1 (rsp_valid && rsp_last));

  a_r3_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid);

  a_r5_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || wr_done) |-> !req_ready);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  a_r6_no_data_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> !rsp_valid);

  a_r8_banks_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rdy == '0) || (bank_rdy == '1));

  a_r8_access_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || wr_done) |-> (&bank_rdy));
endmodule

bind ilv_refill_ctrl ilv_refill_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_last  (rsp_last),
  .wr_done   (wr_done),
  .bank_rdy  (bank_rdy)
);

// File: tb/ilv_refill_ctrl_test.sv
`timescale 1ns/1ps
module ilv_refill_ctrl_test;
  localparam int DW   = 32;
  localparam int BW   = 8;
  localparam int NBLK = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic          req_ready;
  logic [BW-1:0] req_blk;
  logic [127:0]  req_wdata;
  logic          rsp_valid, rsp_last, wr_done;
  logic [DW-1:0] rsp_data;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  logic [127:0]  shadow [NBLK];
  logic [BW-1:0] wlist [64];
  int            wcnt = 0;

  always #2.5 clk = ~clk;

  ilv_refill_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_blk   (req_blk),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .rsp_data  (rsp_data),
    .wr_done   (wr_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [BW-1:0] b, input int k);
    return shadow[b][k*32 +: 32];
  endfunction

  function automatic logic [127:0] rnd_block();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic do_req(input bit wr, input logic [BW-1:0] b,
                        input logic [127:0] wd, input bit noise);
    int last_c;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_blk   = b;
    req_wdata = wd;
    check(req_ready === 1'b1, "R5", "ready before request", 32'(req_ready), 32'd1);
    @(posedge clk);
    if (wr) begin
      shadow[b] = wd;
      if (wcnt < 64) begin
        wlist[wcnt] = b;
        wcnt++;
      end
    end
    last_c = wr ? 18 : 21;
    for (int c = 1; c <= last_c; c++) begin
      @(negedge clk);
      if (noise && c < 12) begin
        req_valid = 1'($urandom);
        req_write = 1'($urandom);
        req_blk   = BW'($urandom);
        req_wdata = rnd_block();
      end else begin
        req_valid = 1'b0;
      end
      if (wr) begin
        check(wr_done === (c == 17), "R6", "write done pulse", 32'(wr_done), 32'(c == 17));
        check(rsp_valid === 1'b0, "R6", "no response on write", 32'(rsp_valid), 32'd0);
        check(req_ready === (c >= 18), "R5", "ready during write", 32'(req_ready), 32'(c >= 18));
      end else begin
        check(rsp_valid === (c >= 17 && c <= 20), (c <= 16) ? "R8" : "R3",
              "valid window", 32'(rsp_valid), 32'(c >= 17 && c <= 20));
        check(rsp_last === (c == 20), "R3", "last flag", 32'(rsp_last), 32'(c == 20));
        check(req_ready === (c >= 21), "R5", "ready during read", 32'(req_ready), 32'(c >= 21));
        check(wr_done === 1'b0, "R6", "no done on read", 32'(wr_done), 32'd0);
        if (c >= 17 && c <= 20)
          check(rsp_data === exp_word(b, c - 17), "R4", "word order/data (R2 R7)",
                rsp_data, exp_word(b, c - 17));
      end
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [127:0] d;
    void'($urandom(32'd2718));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_blk   = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready === 1'b1, "R1", "ready in reset", 32'(req_ready), 32'd1);
    check(rsp_valid === 1'b0, "R1", "valid in reset", 32'(rsp_valid), 32'd0);
    check(rsp_last === 1'b0, "R1", "last in reset", 32'(rsp_last), 32'd0);
    check(wr_done === 1'b0, "R1", "done in reset", 32'(wr_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1", "state after reset",
          {30'd0, req_ready, rsp_valid}, 32'd2);

    // R2: lowest and highest block, distinct word patterns
    do_req(1'b1, 8'h00, {32'h0000_0003, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000}, 1'b0);
    do_req(1'b1, 8'hFF, {32'hFFFF_0003, 32'hFFFF_0002, 32'hFFFF_0001, 32'hFFFF_0000}, 1'b0);
    do_req(1'b0, 8'h00, '0, 1'b0);
    do_req(1'b0, 8'hFF, '0, 1'b0);

    // R5: requests raised while busy are ignored
    do_req(1'b0, 8'h00, '0, 1'b1);

    // random writes, then a random mix of reads and writes
    for (int i = 0; i < 12; i++) do_req(1'b1, BW'($urandom), rnd_block(), 1'($urandom));
    for (int i = 0; i < 30; i++) begin
      if (($urandom % 10) < 3) do_req(1'b1, BW'($urandom), rnd_block(), 1'($urandom));
      else do_req(1'b0, wlist[$urandom % wcnt], '0, 1'($urandom));
    end

    // R7: overwrite and read back
    d = rnd_block();
    do_req(1'b1, 8'h00, d, 1'b0);
    do_req(1'b0, 8'h00, '0, 1'b0);
    do_req(1'b0, 8'hFF, '0, 1'b0);

    finish_run();
  end
endmodule